// File: doc/BRIEF.md
# Mask-Driven Multi-Register Stack Sequencer

This block saves or restores a group of registers to or from a memory stack, one 32-bit register per cycle. It takes a 16-bit selection mask, a direction and a starting stack pointer. It then walks the mask and issues one memory transfer for each set bit. When the walk is finished it reports completion together with the final stack pointer.

In save mode, each register is read from the register file and written to memory at a pointer that is decremented before each store. In restore mode, each word is read from memory at the current pointer and written into the register file, and the pointer is incremented after each load.

Register numbers 0..7 are the data registers D0..D7, and 8..15 are the address registers A0..A7. The mask is scanned from bit 0 upward in both modes. Save mode maps bits to registers in the reverse direction. As a result, a restore whose mask is the bit-reversal of the save mask brings the same registers back in exactly the opposite order.

Top module: `regmask_stack_seq`

## Requirements
- R1: After reset, and whenever the sequencer is idle, `busy_o`, `done_o`, `mem_req_o` and `rf_wr_en_o` are all 0.
- R2: An operation issues exactly as many memory transfers as the mask has set bits. With `mem_ready_i` held at 1, `done_o` rises in the cycle N+1 after the start is sampled, where N is the number of set bits.
- R3: In save mode (`dir_pop_i`=0), mask bit i selects register 15-i, and bits are served from bit 0 upward. The k-th transfer (k from 0) writes the selected register's value to address sp-4*(k+1), with `mem_we_o`=1.
- R4: In restore mode (`dir_pop_i`=1), mask bit i selects register i, and bits are served from bit 0 upward. The k-th transfer reads address sp+4*k with `mem_we_o`=0 and writes the returned word to the selected register.
- R5: `sp_o` shown while `done_o`=1 equals the start pointer minus 4*N in save mode, or plus 4*N in restore mode.
- R6: An all-zero mask makes no memory request. It raises `done_o` in the first cycle after the start, with `sp_o` equal to the start pointer.
- R7: While `mem_req_o`=1 and `mem_ready_i`=0, the request stays up with the same address and direction, no register is written, and the stack pointer does not move.
- R8: A `start_i` pulse during an operation is ignored.
- R9: Saving with mask M and then restoring with the bit-reversal of M, from the pointer the save left behind, visits the same registers in reverse order at the same addresses. The restore returns the stack pointer to its original value.
- R10: `done_o` is a one-cycle pulse, after which the sequencer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin an operation (sampled only when idle) |
| dir_pop_i | input | 1 | 0 = save to stack, 1 = restore from stack |
| mask_i | input | 16 | Register selection mask |
| sp_i | input | 32 | Initial stack pointer |
| rf_rd_en_o | output | 1 | Register file read strobe (save mode) |
| rf_rd_idx_o | output | 4 | Register file read index |
| rf_rd_data_i | input | 32 | Register file read data |
| rf_wr_en_o | output | 1 | Register file write strobe (restore mode) |
| rf_wr_idx_o | output | 4 | Register file write index |
| rf_wr_data_o | output | 32 | Register file write data |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data |
| mem_ready_i | input | 1 | Memory accepts the current request |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sp_o | output | 32 | Current and final stack pointer |

## Verification
The bench targets the two bit-to-register mappings and the predecrement/postincrement address rules. A design that mixed up the mappings would store registers in an order that a reversed-mask restore could not undo. A design that got the address rules wrong would be off by one word at the first or last transfer.

It also covers several timing corners:
- an empty mask, where a design could hang or emit a stray request;
- stalled memory, where a design could advance the pointer or write the register file without a handshake;
- a second start during a run, which could reload the mask partway through.

The save-then-restore round trip compares register order and addresses between the two passes.

// File: rtl/rmss_pkg.sv
package rmss_pkg;
  localparam int unsigned DEF_REGS = 16;
  localparam int unsigned DEF_DW   = 32;
  localparam int unsigned DEF_AW   = 32;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_DONE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/rmss_pick.sv
module rmss_pick #(
  parameter int unsigned REGS = 16,
  localparam int unsigned IW = $clog2(REGS)
) (
  input  logic [REGS-1:0] mask_i,
  output logic [REGS-1:0] grant_o,
  output logic [IW-1:0]   pos_o,
  output logic            any_o
);
  logic [REGS:0] lower_any;

  assign lower_any[0] = 1'b0;

  for (genvar g = 0; g < REGS; g++) begin : g_prio
    assign grant_o[g]     = mask_i[g] & ~lower_any[g];
    assign lower_any[g+1] = lower_any[g] | mask_i[g];
  end

  function automatic logic [IW-1:0] encode_pos(input logic [REGS-1:0] oh);
    logic [IW-1:0] r;
    r = '0;
    for (int i = 0; i < REGS; i++) begin
      if (oh[i]) r = IW'(i);
    end
    return r;
  endfunction

  assign pos_o = encode_pos(grant_o);
  assign any_o = lower_any[REGS];

  // R2
  always_comb begin
    if (!$isunknown(mask_i)) begin
      grant_onehot_chk: assert ($onehot0(grant_o) && (any_o == (grant_o != '0)));
    end
  end
endmodule

// File: rtl/rmss_addr.sv
module rmss_addr #(
  parameter int unsigned AW   = 32,
  parameter int unsigned STEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] sp_init_i,
  input  logic          fire_i,
  input  logic          pop_i,
  output logic [AW-1:0] sp_o,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] sp_q;

  function automatic logic [AW-1:0] step_sp(input logic [AW-1:0] sp, input logic up);
    return up ? sp + AW'(STEP) : sp - AW'(STEP);
  endfunction

  // Restore reads at the current pointer; save stores one word below it.
  function automatic logic [AW-1:0] access_addr(input logic [AW-1:0] sp, input logic up);
    return up ? sp : sp - AW'(STEP);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_q <= '0;
    end else if (load_i) begin
      sp_q <= sp_init_i;
    end else if (fire_i) begin
      sp_q <= step_sp(sp_q, pop_i);
    end
  end

  assign sp_o   = sp_q;
  assign addr_o = access_addr(sp_q, pop_i);

  // R3
  push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i && !pop_i && !load_i) |=> (sp_q == $past(sp_q) - AW'(STEP)));

  // R4
  pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i && pop_i && !load_i) |=> (sp_q == $past(sp_q) + AW'(STEP)));

  // R7
  sp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire_i && !load_i) |=> $stable(sp_q));
endmodule

// File: rtl/rmss_ctrl.sv
module rmss_ctrl
  import rmss_pkg::*;
#(
  parameter int unsigned REGS = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            dir_pop_i,
  input  logic [REGS-1:0] mask_i,
  input  logic [REGS-1:0] grant_i,
  input  logic            mem_ready_i,
  output logic [REGS-1:0] rem_o,
  output logic            pop_o,
  output logic            load_o,
  output logic            req_o,
  output logic            fire_o,
  output logic            busy_o,
  output logic            done_o
);
  seq_state_e      state_q;
  logic [REGS-1:0] rem_q;
  logic            pop_q;
  logic [REGS-1:0] rem_after;
  logic            idle;

  assign idle      = (state_q == ST_IDLE);
  assign load_o    = idle && start_i;
  assign req_o     = (state_q == ST_XFER);
  assign fire_o    = req_o && mem_ready_i;
  assign rem_after = rem_q & ~grant_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      pop_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          rem_q   <= mask_i;
          pop_q   <= dir_pop_i;
          state_q <= (mask_i == '0) ? ST_DONE : ST_XFER;
        end
        ST_XFER: if (mem_ready_i) begin
          rem_q <= rem_after;
          if (rem_after == '0) state_q <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rem_o  = rem_q;
  assign pop_o  = pop_q;
  assign busy_o = !idle;
  assign done_o = (state_q == ST_DONE);

  // R6
  zero_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && start_i && mask_i == '0) |=> (done_o && !req_o));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));

  // R2
  one_bit_per_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> ($countones(rem_q) + 1 == $countones($past(rem_q))));

  // R8
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && start_i && !mem_ready_i) |=> (rem_q == $past(rem_q) && pop_q == $past(pop_q)));
endmodule

// File: rtl/regmask_stack_seq.sv
module regmask_stack_seq #(
  parameter int unsigned REGS = rmss_pkg::DEF_REGS,
  parameter int unsigned DW   = rmss_pkg::DEF_DW,
  parameter int unsigned AW   = rmss_pkg::DEF_AW,
  localparam int unsigned IW  = $clog2(REGS),
  localparam int unsigned STEP = DW / 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            dir_pop_i,
  input  logic [REGS-1:0] mask_i,
  input  logic [AW-1:0]   sp_i,
  output logic            rf_rd_en_o,
  output logic [IW-1:0]   rf_rd_idx_o,
  input  logic [DW-1:0]   rf_rd_data_i,
  output logic            rf_wr_en_o,
  output logic [IW-1:0]   rf_wr_idx_o,
  output logic [DW-1:0]   rf_wr_data_o,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [DW-1:0]   mem_wdata_o,
  input  logic [DW-1:0]   mem_rdata_i,
  input  logic            mem_ready_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [AW-1:0]   sp_o
);
  logic [REGS-1:0] rem;
  logic [REGS-1:0] grant;
  logic [IW-1:0]   bit_pos;
  logic            any_left;
  logic            pop_mode;
  logic            load;
  logic            req;
  logic            fire;
  logic [IW-1:0]   reg_idx;

  // Restore: bit i -> register i. Save: bit i -> register REGS-1-i.
  function automatic logic [IW-1:0] reg_of_bit(input logic [IW-1:0] pos, input logic up);
    return up ? pos : IW'(REGS - 1) - pos;
  endfunction

  rmss_ctrl #(.REGS(REGS)) ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .dir_pop_i   (dir_pop_i),
    .mask_i      (mask_i),
    .grant_i     (grant),
    .mem_ready_i (mem_ready_i),
    .rem_o       (rem),
    .pop_o       (pop_mode),
    .load_o      (load),
    .req_o       (req),
    .fire_o      (fire),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

  rmss_pick #(.REGS(REGS)) pick_i (
    .mask_i  (rem),
    .grant_o (grant),
    .pos_o   (bit_pos),
    .any_o   (any_left)
  );

  rmss_addr #(.AW(AW), .STEP(STEP)) addr_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load),
    .sp_init_i (sp_i),
    .fire_i    (fire),
    .pop_i     (pop_mode),
    .sp_o      (sp_o),
    .addr_o    (mem_addr_o)
  );

  assign reg_idx      = reg_of_bit(bit_pos, pop_mode);
  assign mem_req_o    = req;
  assign mem_we_o     = req && !pop_mode;
  assign mem_wdata_o  = rf_rd_data_i;
  assign rf_rd_en_o   = req && !pop_mode;
  assign rf_rd_idx_o  = reg_idx;
  assign rf_wr_en_o   = fire && pop_mode;
  assign rf_wr_idx_o  = reg_idx;
  assign rf_wr_data_o = mem_rdata_i;

  // R2
  req_has_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> any_left);

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ready_i) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(rf_rd_idx_o)));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!mem_req_o && !rf_wr_en_o && !done_o));
endmodule

// File: tb/regmask_stack_seq_tb_top.sv
`timescale 1ns/1ps
module regmask_stack_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        dir_pop_i = 1'b0;
  logic [15:0] mask_i = '0;
  logic [31:0] sp_i = '0;
  logic        mem_ready_i = 1'b1;
  logic        rf_rd_en_o, rf_wr_en_o, mem_req_o, mem_we_o, busy_o, done_o;
  logic [3:0]  rf_rd_idx_o, rf_wr_idx_o;
  logic [31:0] rf_rd_data_i, rf_wr_data_o, mem_addr_o, mem_wdata_o, mem_rdata_i, sp_o;

  always #2.5 clk = ~clk;

  regmask_stack_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dir_pop_i(dir_pop_i),
    .mask_i(mask_i), .sp_i(sp_i),
    .rf_rd_en_o(rf_rd_en_o), .rf_rd_idx_o(rf_rd_idx_o), .rf_rd_data_i(rf_rd_data_i),
    .rf_wr_en_o(rf_wr_en_o), .rf_wr_idx_o(rf_wr_idx_o), .rf_wr_data_o(rf_wr_data_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .mem_ready_i(mem_ready_i),
    .busy_o(busy_o), .done_o(done_o), .sp_o(sp_o)
  );

  // Bench-side register file, memory and transfer log
  logic [31:0] regm [16];
  logic [31:0] memm [64];
  logic [31:0] log_addr [17];
  logic [31:0] log_data [17];
  logic [3:0]  log_reg  [17];
  logic        log_we   [17];
  int          log_n;
  logic        log_clr = 1'b0;

  assign rf_rd_data_i = regm[rf_rd_idx_o];
  assign mem_rdata_i  = memm[mem_addr_o[7:2]];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) regm[i] <= 32'hA000_0000 + i;
      for (int i = 0; i < 64; i++) memm[i] <= 32'h5000_0000 + 32'(i * 16);
      log_n <= 0;
    end else begin
      if (mem_req_o && mem_ready_i && mem_we_o) memm[mem_addr_o[7:2]] <= mem_wdata_o;
      if (rf_wr_en_o) regm[rf_wr_idx_o] <= rf_wr_data_o;
      if (log_clr) log_n <= 0;
      else if (mem_req_o && mem_ready_i && log_n < 17) begin
        log_addr[log_n] <= mem_addr_o;
        log_we[log_n]   <= mem_we_o;
        log_reg[log_n]  <= mem_we_o ? rf_rd_idx_o : rf_wr_idx_o;
        log_data[log_n] <= mem_we_o ? mem_wdata_o : rf_wr_data_o;
        log_n <= log_n + 1;
      end
    end
  end

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // {dir_pop, stall, mask, sp}
  localparam logic [49:0] VEC [8] = '{
    {1'b0, 1'b0, 16'h010F, 32'h0000_1080},
    {1'b1, 1'b0, 16'hF080, 32'h0000_1040},
    {1'b0, 1'b1, 16'hFFFF, 32'h0000_10C0},
    {1'b1, 1'b1, 16'hFFFF, 32'h0000_1000},
    {1'b0, 1'b0, 16'h0000, 32'h0000_1020},
    {1'b1, 1'b0, 16'h0000, 32'h0000_1030},
    {1'b0, 1'b0, 16'h8001, 32'h0000_1090},
    {1'b1, 1'b0, 16'h8000, 32'h0000_10F0}
  };

  int lat;

  task automatic run_op(input logic d, input logic stall, input logic [15:0] m,
                        input logic [31:0] sp);
    @(negedge clk);
    log_clr = 1'b1; start_i = 1'b1; dir_pop_i = d; mask_i = m; sp_i = sp;
    mem_ready_i = 1'b1;
    @(negedge clk);
    log_clr = 1'b0; start_i = 1'b0;
    lat = -1;
    for (int cyc = 1; cyc < 80; cyc++) begin
      if (done_o) begin lat = cyc; break; end
      mem_ready_i = stall ? cyc[0] : 1'b1;
      @(negedge clk);
    end
    mem_ready_i = 1'b1;
  endtask

  task automatic check_log(input logic d, input logic [15:0] m, input logic [31:0] sp,
                           input string tag);
    int k = 0;
    for (int b = 0; b < 16; b++) begin
      if (m[b]) begin
        logic [3:0]  er = d ? 4'(b) : 4'(15 - b);
        logic [31:0] ea = d ? sp + 32'(4 * k) : sp - 32'(4 * (k + 1));
        logic [31:0] ed = d ? memm[ea[7:2]] : regm[er];
        chk(log_reg[k] == er, tag, "register index", 32'(log_reg[k]), 32'(er));
        chk(log_addr[k] == ea, tag, "address", log_addr[k], ea);
        chk(log_we[k] == !d, tag, "direction", 32'(log_we[k]), 32'(!d));
        chk(log_data[k] == ed, tag, "data", log_data[k], ed);
        k++;
      end
    end
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] push_addr [5];
    logic [3:0]  push_reg  [5];
    logic [31:0] push_data [5];

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy_o && !done_o && !mem_req_o && !rf_wr_en_o, "R1", "idle outputs",
        {busy_o, done_o, mem_req_o, rf_wr_en_o}, 32'h0);

    // Table walk: R2 R3 R4 R5 R6 R10
    foreach (VEC[v]) begin
      logic        d  = VEC[v][49];
      logic        st = VEC[v][48];
      logic [15:0] m  = VEC[v][47:32];
      logic [31:0] sp = VEC[v][31:0];
      int          n  = $countones(m);
      run_op(d, st, m, sp);
      chk(log_n == n, "R2", "transfer count", 32'(log_n), 32'(n));
      if (!st) chk(lat == n + 1, (n == 0) ? "R6" : "R2", "done latency", 32'(lat), 32'(n + 1));
      chk(sp_o == (d ? sp + 32'(4 * n) : sp - 32'(4 * n)), "R5", "final sp",
          sp_o, d ? sp + 32'(4 * n) : sp - 32'(4 * n));
      check_log(d, m, sp, d ? "R4" : "R3");
      @(negedge clk);
      chk(!done_o && !busy_o, "R10", "done pulse width", {done_o, busy_o}, 32'h0);
    end

    // R7 stall: hold ready low
    @(negedge clk);
    log_clr = 1'b1; start_i = 1'b1; dir_pop_i = 1'b0; mask_i = 16'h0003; sp_i = 32'h1080;
    mem_ready_i = 1'b0;
    @(negedge clk);
    log_clr = 1'b0; start_i = 1'b0;
    chk(mem_req_o && mem_addr_o == 32'h107C && mem_we_o, "R7", "request raised",
        mem_addr_o, 32'h107C);
    repeat (3) @(negedge clk);
    chk(mem_req_o && mem_addr_o == 32'h107C, "R7", "address held", mem_addr_o, 32'h107C);
    chk(log_n == 0 && sp_o == 32'h1080, "R7", "no progress while stalled", sp_o, 32'h1080);
    mem_ready_i = 1'b1;
    repeat (3) @(negedge clk);
    chk(sp_o == 32'h1078 && log_n == 2, "R7", "completes after release", sp_o, 32'h1078);

    // R8 start during an operation
    @(negedge clk);
    log_clr = 1'b1; start_i = 1'b1; dir_pop_i = 1'b1; mask_i = 16'h0001; sp_i = 32'h1000;
    mem_ready_i = 1'b0;
    @(negedge clk);
    log_clr = 1'b0; dir_pop_i = 1'b0; mask_i = 16'hFFFF; sp_i = 32'h1080;
    @(negedge clk);
    start_i = 1'b0; mem_ready_i = 1'b1;
    repeat (4) @(negedge clk);
    chk(log_n == 1, "R8", "transfer count", 32'(log_n), 32'd1);
    chk(sp_o == 32'h1004, "R8", "final sp", sp_o, 32'h1004);

    // R9 save then reversed-mask restore
    run_op(1'b0, 1'b0, 16'h010F, 32'h1080);
    for (int k = 0; k < 5; k++) begin
      push_addr[k] = log_addr[k]; push_reg[k] = log_reg[k]; push_data[k] = log_data[k];
    end
    run_op(1'b1, 1'b0, 16'hF080, sp_o);
    chk(log_n == 5, "R9", "restore count", 32'(log_n), 32'd5);
    for (int k = 0; k < 5; k++) begin
      chk(log_reg[k] == push_reg[4 - k], "R9", "reverse order", 32'(log_reg[k]),
          32'(push_reg[4 - k]));
      chk(log_addr[k] == push_addr[4 - k], "R9", "matching address", log_addr[k],
          push_addr[4 - k]);
      chk(log_data[k] == push_data[4 - k], "R9", "restored value", log_data[k],
          push_data[4 - k]);
    end
    chk(sp_o == 32'h1080, "R9", "sp returns", sp_o, 32'h1080);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule